// File: doc/BRIEF.md
# Edge-Triggered Capture Timer with Interrupt Status

This block keeps a free-running counter that advances by one on each cycle in which a tick enable is high. A separate clock-enable generator supplies that tick at roughly 616.6 kHz. Two slow external lines, a barcode wand and a tape read head, are synchronized into the clock domain. The block watches whichever line a source-select bit picks, on the edge or edges that a 2-bit trigger code picks. When the chosen edge arrives, the current count is copied into a capture register, so software can time-stamp transitions of the line.

The block also holds a five-bit interrupt status register and an enable mask with the same bit layout. The counter wrap and the capture event set two of the status bits. The other three bits are set by request pulses from the serial receiver, the keyboard controller and an expansion port. Each bit has its own way of being cleared: a control write, a register read, or an acknowledge pulse. The interrupt output is high while any pending bit is also enabled.

The counter is read through a snapshot pair so that a 16-bit value can be taken as two bytes without tearing. All registers sit on a simple strobe bus with a combinational read path.

Top module: `capture_timer_irq`

## Requirements
- R1: On reset every register is zero: counter, capture, snapshot, trigger configuration (code 00, tape source), status, enable, and `irq` is low.
- R2: The counter increments by one on each clock edge where `tick` is 1, holds while `tick` is 0, and wraps from 0xFFFF to 0x0000.
- R3: A tick that wraps the counter sets status bit 3. Writing address 1 with data bit 2 = 1 clears bit 3, and writing address 1 with data bit 2 = 0 leaves it unchanged.
- R4: Writing address 0 sets the trigger code from data bits 1:0. The codes are: 00 never captures, 01 captures on a falling edge, 10 on a rising edge, 11 on both edges.
- R5: Data bit 2 of the address-0 write picks the trigger line: 1 is the barcode line, 0 is the tape line. Edges on the unselected line never capture.
- R6: Each trigger line passes through a two-stage synchronizer. A line change driven before clock edge E1 updates the capture register at edge E3 with the counter value present before E3.
- R7: A capture sets status bit 2. Reading address 3 (capture high byte) clears it, and reading address 2 (capture low byte) does not.
- R8: Reading address 0 returns the live low byte of the counter and freezes the high byte. A later read of address 1 returns that frozen byte even if the counter has moved on.
- R9: Status bit 1 is set by `rx_req` and cleared by `rx_rd`. Bit 0 is set by `kbd_req` and cleared by `kbd_ack`. Bit 4 is set by `ext_req` and cleared by `ext_ack`. Status is read at address 4, bits 4:0.
- R10: Writing address 4 loads the enable mask (data bits 4:0, same layout as status). Status bits latch whatever the mask holds. `irq` is high exactly while some status bit and its enable bit are both 1.
- R11: Reading address 5 returns the synchronized barcode level on bit 1 and the synchronized tape level on bit 0, with the other bits zero.
- R12: When a set and a clear of the same status bit fall in one cycle, the set wins and the bit reads 1 afterwards.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| tick | input | 1 | Counter advance enable |
| bar_in | input | 1 | Barcode line, asynchronous |
| tape_in | input | 1 | Tape line, asynchronous |
| bus_addr | input | 3 | Register address |
| bus_wr | input | 1 | Write strobe |
| bus_rd | input | 1 | Read strobe (read side effects) |
| bus_wdata | input | 8 | Write data |
| bus_rdata | output | 8 | Read data, combinational from `bus_addr` |
| kbd_req | input | 1 | Keyboard controller request pulse |
| kbd_ack | input | 1 | Keyboard controller acknowledge pulse |
| rx_req | input | 1 | Serial receive-ready pulse |
| rx_rd | input | 1 | Serial data-read pulse |
| ext_req | input | 1 | Expansion request pulse |
| ext_ack | input | 1 | Expansion acknowledge pulse |
| irq | output | 1 | Interrupt request |

## Verification
Two functions can land on the same status bit in one cycle. A capture can set bit 2 in the very cycle that a read of the capture high byte clears it. A counter wrap can set bit 3 in the cycle that a control write clears it. The bench causes the first by toggling the tape line and timing the read so that it falls on the third edge after the toggle. It causes the second by placing the clearing write on the final tick of a full 65536-tick lap. In both cases the status bit must read 1 afterwards. The same collision is also forced on the receive-ready bit.

// File: rtl/cti_pkg.sv
package cti_pkg;
   typedef enum logic [1:0] {
      TRG_OFF  = 2'b00,
      TRG_FALL = 2'b01,
      TRG_RISE = 2'b10,
      TRG_BOTH = 2'b11
   } trg_mode_e;

   localparam int ADDR_W = 3;
   localparam int N_SRC  = 5;

   // read map
   localparam logic [ADDR_W-1:0] A_CNT_LO = 3'd0;
   localparam logic [ADDR_W-1:0] A_CNT_HI = 3'd1;
   localparam logic [ADDR_W-1:0] A_CAP_LO = 3'd2;
   localparam logic [ADDR_W-1:0] A_CAP_HI = 3'd3;
   localparam logic [ADDR_W-1:0] A_STS    = 3'd4;
   localparam logic [ADDR_W-1:0] A_LVL    = 3'd5;
   // write map
   localparam logic [ADDR_W-1:0] A_CFG    = 3'd0;
   localparam logic [ADDR_W-1:0] A_CTRL   = 3'd1;
   localparam logic [ADDR_W-1:0] A_IEN    = 3'd4;

   // status bit positions
   localparam int IRQ_KBD = 0;
   localparam int IRQ_RX  = 1;
   localparam int IRQ_CAP = 2;
   localparam int IRQ_OVF = 3;
   localparam int IRQ_EXT = 4;

   localparam int CTRL_OVF_CLR = 2;
   localparam int CFG_SRC_BIT  = 2;
endpackage

// File: rtl/cti_sync.sv
module cti_sync #(
   parameter int STAGES = 2
) (
   input  logic clk,
   input  logic rst_n,
   input  logic d,
   output logic q
);
   generate
      if (STAGES < 2) begin : g_bad
         $error("cti_sync needs at least two stages");
      end
   endgenerate

   logic [STAGES-1:0] chain;

   always_ff @(posedge clk) begin
      if (!rst_n) chain <= '0;
      else        chain <= {chain[STAGES-2:0], d};
   end

   assign q = chain[STAGES-1];
endmodule

// File: rtl/cti_edge_sel.sv
module cti_edge_sel
   import cti_pkg::*;
(
   input  logic      clk,
   input  logic      rst_n,
   input  logic      bar_s,
   input  logic      tape_s,
   input  trg_mode_e mode,
   input  logic      use_bar,
   output logic      evt
);
   logic bar_d, tape_d;
   logic cur, prv, rise, fall;

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         bar_d  <= 1'b0;
         tape_d <= 1'b0;
      end else begin
         bar_d  <= bar_s;
         tape_d <= tape_s;
      end
   end

   assign cur  = use_bar ? bar_s : tape_s;
   assign prv  = use_bar ? bar_d : tape_d;
   assign rise = cur & ~prv;
   assign fall = ~cur & prv;

   always_comb begin
      unique case (mode)
         TRG_FALL: evt = fall;
         TRG_RISE: evt = rise;
         TRG_BOTH: evt = rise | fall;
         default:  evt = 1'b0;
      endcase
   end

   // R4: code 00 never fires
   p_off_quiet_r4: assert property (@(posedge clk) disable iff (!rst_n)
      (mode == TRG_OFF) |-> !evt);
   // R5: with barcode selected, a quiet barcode line cannot fire
   p_unsel_quiet_r5: assert property (@(posedge clk) disable iff (!rst_n)
      (use_bar && (bar_s == bar_d)) |-> !evt);
   // R4: a rising-only trigger fires only with the line high
   p_rise_level_r4: assert property (@(posedge clk) disable iff (!rst_n)
      (evt && mode == TRG_RISE) |-> cur);
endmodule

// File: rtl/cti_counter.sv
module cti_counter #(
   parameter int DATA_W = 8,
   parameter int CNT_W  = 2 * DATA_W
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              tick,
   input  logic              rd_lo,
   output logic [CNT_W-1:0]  cnt,
   output logic              wrap,
   output logic [DATA_W-1:0] hold
);
   localparam logic [CNT_W-1:0] CNT_MAX = '1;

   generate
      if (CNT_W != 2 * DATA_W) begin : g_bad
         $error("counter must be two bus bytes wide");
      end
   endgenerate

   assign wrap = tick && (cnt == CNT_MAX);

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         cnt  <= '0;
         hold <= '0;
      end else begin
         if (tick)  cnt  <= cnt + 1'b1;
         if (rd_lo) hold <= cnt[CNT_W-1:DATA_W];
      end
   end

   p_step_r2: assert property (@(posedge clk) disable iff (!rst_n)
      (tick && cnt != CNT_MAX) |=> (cnt == $past(cnt) + 1'b1));
   p_idle_r2: assert property (@(posedge clk) disable iff (!rst_n)
      !tick |=> $stable(cnt));
   p_wrap_zero_r3: assert property (@(posedge clk) disable iff (!rst_n)
      wrap |=> (cnt == '0));
   p_freeze_r8: assert property (@(posedge clk) disable iff (!rst_n)
      !rd_lo |=> $stable(hold));
endmodule

// File: rtl/cti_irq.sv
module cti_irq #(
   parameter int N = 5
) (
   input  logic         clk,
   input  logic         rst_n,
   input  logic [N-1:0] set,
   input  logic [N-1:0] clr,
   input  logic         en_wr,
   input  logic [N-1:0] en_din,
   output logic [N-1:0] sts,
   output logic [N-1:0] en,
   output logic         irq
);
   always_ff @(posedge clk) begin
      if (!rst_n)     en <= '0;
      else if (en_wr) en <= en_din;
   end

   generate
      for (genvar i = 0; i < N; i++) begin : g_bit
         always_ff @(posedge clk) begin
            if (!rst_n)      sts[i] <= 1'b0;
            else if (set[i]) sts[i] <= 1'b1;
            else if (clr[i]) sts[i] <= 1'b0;
         end

         // R12: set dominates a same-cycle clear
         p_set_wins_r12: assert property (@(posedge clk) disable iff (!rst_n)
            set[i] |=> sts[i]);
         p_clear_r9: assert property (@(posedge clk) disable iff (!rst_n)
            (clr[i] && !set[i]) |=> !sts[i]);
         // R10: pending bits hold regardless of the enable mask
         p_latch_r10: assert property (@(posedge clk) disable iff (!rst_n)
            (!clr[i] && !set[i]) |=> $stable(sts[i]));
      end
   endgenerate

   assign irq = |(sts & en);
endmodule

// File: rtl/capture_timer_irq.sv
module capture_timer_irq
   import cti_pkg::*;
#(
   parameter int DATA_W      = 8,
   parameter int SYNC_STAGES = 2
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              tick,
   input  logic              bar_in,
   input  logic              tape_in,
   input  logic [ADDR_W-1:0] bus_addr,
   input  logic              bus_wr,
   input  logic              bus_rd,
   input  logic [DATA_W-1:0] bus_wdata,
   output logic [DATA_W-1:0] bus_rdata,
   input  logic              kbd_req,
   input  logic              kbd_ack,
   input  logic              rx_req,
   input  logic              rx_rd,
   input  logic              ext_req,
   input  logic              ext_ack,
   output logic              irq
);
   localparam int CNT_W = 2 * DATA_W;

   generate
      if (DATA_W < N_SRC) begin : g_bad
         $error("bus too narrow for status");
      end
   endgenerate

   logic              bar_s, tape_s, cap_evt, wrap;
   logic [CNT_W-1:0]  cnt, cap_q;
   logic [DATA_W-1:0] hold;
   trg_mode_e         mode_q;
   logic              use_bar_q;
   logic [N_SRC-1:0]  set_v, clr_v, sts, en;
   logic              wr_cfg, wr_ctrl, wr_ien, rd_lo, rd_caphi;

   assign wr_cfg   = bus_wr && (bus_addr == A_CFG);
   assign wr_ctrl  = bus_wr && (bus_addr == A_CTRL);
   assign wr_ien   = bus_wr && (bus_addr == A_IEN);
   assign rd_lo    = bus_rd && (bus_addr == A_CNT_LO);
   assign rd_caphi = bus_rd && (bus_addr == A_CAP_HI);

   cti_sync #(.STAGES(SYNC_STAGES)) u_sync_bar (
      .clk(clk), .rst_n(rst_n), .d(bar_in), .q(bar_s));
   cti_sync #(.STAGES(SYNC_STAGES)) u_sync_tape (
      .clk(clk), .rst_n(rst_n), .d(tape_in), .q(tape_s));

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         mode_q    <= TRG_OFF;
         use_bar_q <= 1'b0;
      end else if (wr_cfg) begin
         mode_q    <= trg_mode_e'(bus_wdata[1:0]);
         use_bar_q <= bus_wdata[CFG_SRC_BIT];
      end
   end

   cti_edge_sel u_edge (
      .clk(clk), .rst_n(rst_n), .bar_s(bar_s), .tape_s(tape_s),
      .mode(mode_q), .use_bar(use_bar_q), .evt(cap_evt));

   cti_counter #(.DATA_W(DATA_W), .CNT_W(CNT_W)) u_cnt (
      .clk(clk), .rst_n(rst_n), .tick(tick), .rd_lo(rd_lo),
      .cnt(cnt), .wrap(wrap), .hold(hold));

   always_ff @(posedge clk) begin
      if (!rst_n)       cap_q <= '0;
      else if (cap_evt) cap_q <= cnt;
   end

   always_comb begin
      set_v          = '0;
      clr_v          = '0;
      set_v[IRQ_KBD] = kbd_req;
      set_v[IRQ_RX]  = rx_req;
      set_v[IRQ_CAP] = cap_evt;
      set_v[IRQ_OVF] = wrap;
      set_v[IRQ_EXT] = ext_req;
      clr_v[IRQ_KBD] = kbd_ack;
      clr_v[IRQ_RX]  = rx_rd;
      clr_v[IRQ_CAP] = rd_caphi;
      clr_v[IRQ_OVF] = wr_ctrl && bus_wdata[CTRL_OVF_CLR];
      clr_v[IRQ_EXT] = ext_ack;
   end

   cti_irq #(.N(N_SRC)) u_irq (
      .clk(clk), .rst_n(rst_n), .set(set_v), .clr(clr_v),
      .en_wr(wr_ien), .en_din(bus_wdata[N_SRC-1:0]),
      .sts(sts), .en(en), .irq(irq));

   always_comb begin
      bus_rdata = '0;
      unique case (bus_addr)
         A_CNT_LO: bus_rdata = cnt[DATA_W-1:0];
         A_CNT_HI: bus_rdata = hold;
         A_CAP_LO: bus_rdata = cap_q[DATA_W-1:0];
         A_CAP_HI: bus_rdata = cap_q[CNT_W-1:DATA_W];
         A_STS:    bus_rdata[N_SRC-1:0] = sts;
         A_LVL:    bus_rdata[1:0] = {bar_s, tape_s};
         default:  bus_rdata = '0;
      endcase
   end

   // R6: capture takes the count seen in the event cycle
   p_cap_latch_r6: assert property (@(posedge clk) disable iff (!rst_n)
      cap_evt |=> (cap_q == $past(cnt)));
   // R7: no event, no change of the capture register
   p_cap_hold_r7: assert property (@(posedge clk) disable iff (!rst_n)
      !cap_evt |=> $stable(cap_q));
   // R3: overflow flag rises only on a counter wrap
   p_ovf_cause_r3: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(sts[IRQ_OVF]) |-> (cnt == '0));
endmodule

// File: tb/sim_capture_timer_irq.sv
module sim_capture_timer_irq;
   import cti_pkg::*;

   logic       clk = 1'b0;
   logic       rst_n = 1'b0;
   logic       tick = 1'b0, bar_in = 1'b0, tape_in = 1'b0;
   logic [2:0] bus_addr = '0;
   logic       bus_wr = 1'b0, bus_rd = 1'b0;
   logic [7:0] bus_wdata = '0;
   logic [7:0] bus_rdata;
   logic       kbd_req = 0, kbd_ack = 0, rx_req = 0, rx_rd = 0, ext_req = 0, ext_ack = 0;
   logic       irq;

   int total = 0;
   int bad = 0;
   bit done = 0;

   always #2 clk = ~clk;

   capture_timer_irq u0 (
      .clk(clk), .rst_n(rst_n), .tick(tick), .bar_in(bar_in), .tape_in(tape_in),
      .bus_addr(bus_addr), .bus_wr(bus_wr), .bus_rd(bus_rd), .bus_wdata(bus_wdata),
      .bus_rdata(bus_rdata), .kbd_req(kbd_req), .kbd_ack(kbd_ack), .rx_req(rx_req),
      .rx_rd(rx_rd), .ext_req(ext_req), .ext_ack(ext_ack), .irq(irq));

   // {exp, on_bar, end, start, src, mode[1:0]}
   localparam logic [6:0] VEC [12] = '{
      7'b1101101, 7'b0110101, 7'b1110110, 7'b0101110,
      7'b1110111, 7'b1101111, 7'b0110100, 7'b1010010,
      7'b1001001, 7'b0110011, 7'b0010111, 7'b0001000 };

   task automatic chk(input string req, input int act, input int exp);
      total++;
      if (act != exp) begin
         bad++;
         $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
      end
   endtask

   task automatic wr(input logic [2:0] a, input logic [7:0] d);
      @(negedge clk); bus_wr = 1; bus_addr = a; bus_wdata = d;
      @(negedge clk); bus_wr = 0;
   endtask

   task automatic rd(input logic [2:0] a, output logic [7:0] d);
      @(negedge clk); bus_rd = 1; bus_addr = a; #1 d = bus_rdata;
      @(negedge clk); bus_rd = 0;
   endtask

   task automatic run_ticks(input int n);
      @(negedge clk); tick = 1;
      repeat (n) @(negedge clk);
      tick = 0;
   endtask

   task automatic idle(input int n);
      repeat (n) @(negedge clk);
   endtask

   initial begin
      repeat (180000) @(posedge clk);
      if (!done) begin
         total++; bad++;
         $display("FAIL watchdog actual=hung expected=finished");
         $display("  test done: total=%0d bad=%0d", total, bad);
         $finish;
      end
   end

   initial begin
      logic [7:0] d;
      repeat (3) @(negedge clk);
      rst_n = 1;
      // R1 reset state
      chk("R1 irq", irq, 0);
      rd(A_STS, d);    chk("R1 status", d, 0);
      rd(A_CAP_LO, d); chk("R1 cap lo", d, 0);
      rd(A_CNT_LO, d); chk("R1 cnt lo", d, 0);

      // R2: 300 ticks -> 0x012C
      run_ticks(300);
      idle(2);
      rd(A_CNT_LO, d); chk("R2 cnt lo held", d, 8'h2C);

      // R4/R5/R7 table of trigger vectors
      for (int i = 0; i < 12; i++) begin
         logic [6:0] v;
         v = VEC[i];
         wr(A_CFG, 8'h00);
         @(negedge clk); bar_in = v[3]; tape_in = v[3];
         idle(5);
         rd(A_CAP_HI, d);
         wr(A_CFG, {5'b0, v[2], v[1:0]});
         @(negedge clk);
         if (v[5]) bar_in = v[4]; else tape_in = v[4];
         idle(5);
         rd(A_STS, d);
         chk($sformatf("R4 R5 vector %0d capture flag", i), d[IRQ_CAP], v[6]);
      end

      // R6 captured value, R7 read low keeps flag
      wr(A_CFG, 8'h00);
      @(negedge clk); bar_in = 0; tape_in = 0;
      idle(5);
      rd(A_CAP_HI, d);
      wr(A_CFG, 8'h06);
      @(negedge clk); bar_in = 1;
      idle(5);
      rd(A_CAP_LO, d); chk("R6 cap lo", d, 8'h2C);
      rd(A_STS, d);    chk("R7 flag after low read", d[IRQ_CAP], 1);
      rd(A_CAP_HI, d); chk("R6 cap hi", d, 8'h01);
      rd(A_STS, d);    chk("R7 flag cleared by high read", d[IRQ_CAP], 0);

      // R6 timing + R12 capture set vs high-read clear in one cycle
      wr(A_CFG, 8'h03);
      @(negedge clk); tape_in = 1;
      @(negedge clk);
      rd(A_CAP_HI, d);
      rd(A_STS, d);    chk("R12 capture set beats read clear", d[IRQ_CAP], 1);
      rd(A_CAP_HI, d);
      rd(A_STS, d);    chk("R7 cleared after second read", d[IRQ_CAP], 0);

      // R11 levels
      wr(A_CFG, 8'h00);
      @(negedge clk); bar_in = 1; tape_in = 0;
      idle(4);
      rd(A_LVL, d); chk("R11 levels bar", d, 8'h02);
      @(negedge clk); bar_in = 0; tape_in = 1;
      idle(4);
      rd(A_LVL, d); chk("R11 levels tape", d, 8'h01);

      // R8 snapshot freeze
      rd(A_CNT_LO, d); chk("R8 live low", d, 8'h2C);
      run_ticks(256);
      rd(A_CNT_HI, d); chk("R8 frozen high", d, 8'h01);
      rd(A_CNT_LO, d); chk("R8 low after lap", d, 8'h2C);
      rd(A_CNT_HI, d); chk("R8 new high", d, 8'h02);

      // R9 / R10 other sources and enable mask
      @(negedge clk); rx_req = 1; @(negedge clk); rx_req = 0;
      rd(A_STS, d); chk("R9 rx set", d[IRQ_RX], 1);
      chk("R10 masked irq", irq, 0);
      wr(A_IEN, 8'h02);
      chk("R10 enabled irq", irq, 1);
      @(negedge clk); rx_rd = 1; @(negedge clk); rx_rd = 0;
      rd(A_STS, d); chk("R9 rx cleared", d[IRQ_RX], 0);
      chk("R10 irq drops", irq, 0);
      @(negedge clk); rx_req = 1; rx_rd = 1; @(negedge clk); rx_req = 0; rx_rd = 0;
      rd(A_STS, d); chk("R12 rx set beats clear", d[IRQ_RX], 1);
      @(negedge clk); rx_rd = 1; @(negedge clk); rx_rd = 0;
      @(negedge clk); kbd_req = 1; ext_req = 1; @(negedge clk); kbd_req = 0; ext_req = 0;
      rd(A_STS, d); chk("R9 kbd and ext set", d, 8'h11);
      chk("R10 irq off with mask 02", irq, 0);
      wr(A_IEN, 8'h10);
      chk("R10 irq on ext", irq, 1);
      @(negedge clk); ext_ack = 1; @(negedge clk); ext_ack = 0;
      chk("R10 irq off after ext ack", irq, 0);
      @(negedge clk); kbd_ack = 1; @(negedge clk); kbd_ack = 0;
      rd(A_STS, d); chk("R9 all cleared", d, 8'h00);
      wr(A_IEN, 8'h00);

      // R2/R3 wrap from 0x022C
      run_ticks(64979);
      rd(A_STS, d); chk("R3 no overflow before wrap", d[IRQ_OVF], 0);
      run_ticks(1);
      rd(A_STS, d); chk("R3 overflow on wrap", d[IRQ_OVF], 1);
      rd(A_CNT_LO, d); chk("R2 wrapped low", d, 8'h00);
      rd(A_CNT_HI, d); chk("R2 wrapped high", d, 8'h00);
      wr(A_CTRL, 8'h00);
      rd(A_STS, d); chk("R3 zero write keeps flag", d[IRQ_OVF], 1);
      wr(A_CTRL, 8'h04);
      rd(A_STS, d); chk("R3 clear write", d[IRQ_OVF], 0);

      // R12 wrap and clearing write in the same cycle
      @(negedge clk); tick = 1;
      repeat (65535) @(negedge clk);
      bus_wr = 1; bus_addr = A_CTRL; bus_wdata = 8'h04;
      @(negedge clk); tick = 0; bus_wr = 0;
      rd(A_STS, d); chk("R12 wrap set beats clear", d[IRQ_OVF], 1);

      done = 1;
      $display("  test done: total=%0d bad=%0d", total, bad);
      $finish;
   end
endmodule